// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit decides where a 16-bit processor fetches next after a control-flow instruction. For each instruction it is handed, together with the already incremented program counter, the value of the register named by bits 8:6, and the current negative/zero/positive condition flags, it returns the next program counter. It also returns a link-register write (to R7) for subroutine calls and service calls. Conditional branches, register jumps (including return), PC-relative and register-based subroutine calls, and vectored service calls are covered. Any other opcode simply continues at the incremented PC.

The next-PC source is one of three: the incremented PC, a computed target (PC plus a sign-extended offset, or the base register), or a word fetched from a service-vector table in memory at a zero-extended 8-bit index. Results are registered and appear one clock after an instruction is accepted. A service call needs one extra clock to read the vector table. During that clock the unit raises `busy`, reads the table through its own read port, and ignores any offered instruction.

Top module: `npc_unit`

## Requirements
- R1: After reset, `npc_vld`, `link_we`, `vec_re` and `busy` are all low.
- R2: A conditional branch (opcode bits 15:12 = 0000) reads mask bits 11 (negative), 10 (zero) and 9 (positive) against `cc[2]`, `cc[1]` and `cc[0]`. If any masked flag is set, `npc` is `pc_inc` plus the sign-extended bits 8:0. Otherwise `npc` is `pc_inc`. No link write is made. The result appears one clock after acceptance, and addition wraps modulo 2^16.
- R3: A conditional branch with all three mask bits clear is never taken, whatever the flags are: `npc` equals `pc_inc`.
- R4: A register jump (opcode 1100) gives `npc` equal to `base_val`, with no link write. A return is the same instruction with base register 7.
- R5: A subroutine call (opcode 0100) with bit 11 set gives `npc` = `pc_inc` + sign-extended bits 10:0. It asserts `link_we` with `link_data` = `pc_inc` in the same cycle as `npc_vld`.
- R6: A subroutine call with bit 11 clear gives `npc` = `base_val`, as sampled when the instruction is accepted, and links `pc_inc`. With base register 7, the jump target is the old R7 value, not the link value.
- R7: A service call (opcode 1111) raises `vec_re` and `busy` for exactly one clock after acceptance, with `vec_addr` = zero-extended bits 7:0. On the next clock, `npc` = the `vec_rdata` sampled during that read, and the unit links the call's `pc_inc`.
- R8: Any other opcode gives `npc` = `pc_inc` with no link write.
- R9: While `busy` is high, `ins_vld` is ignored: no result is produced for an instruction offered then.
- R10: `npc_vld` pulses for exactly one clock per accepted instruction. `link_we` is only ever high together with `npc_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_vld | input | 1 | Instruction offered this cycle |
| ins | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the instruction plus one |
| base_val | input | 16 | Contents of the register named by ins[8:6] |
| cc | input | 3 | Condition flags {negative, zero, positive} |
| vec_rdata | input | 16 | Read data of the vector table, valid while vec_re is high |
| busy | output | 1 | Vector read in progress; offered instructions are ignored |
| npc | output | 16 | Next program counter |
| npc_vld | output | 1 | npc is valid this cycle |
| link_we | output | 1 | Write link_data into R7 |
| link_data | output | 16 | Return address to be linked |
| vec_re | output | 1 | Vector table read strobe |
| vec_addr | output | 16 | Vector table address |

## Verification
The link write and the next-PC result are two functions that land in the same output cycle. A register-based call through R7 is driven with a base value that differs from the incremented PC. The bench then judges that cycle: `npc` must carry the old R7 contents while `link_data` carries the return address. The second overlap is a new instruction offered in the very cycle a service-call vector read is under way. This is provoked by holding a jump on the inputs while `busy` is high; the check is that only the service call's result ever emerges. Back-to-back instructions, negative offsets and a wrapping branch are also driven through the same scoreboard.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned IW = 16;

  localparam logic [3:0] OP_BRC  = 4'b0000;
  localparam logic [3:0] OP_CALL = 4'b0100;
  localparam logic [3:0] OP_JREG = 4'b1100;
  localparam logic [3:0] OP_SVC  = 4'b1111;

  typedef enum logic [1:0] {
    SEL_INC = 2'd0,
    SEL_TGT = 2'd1,
    SEL_VEC = 2'd2
  } npc_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_VEC  = 1'b1
  } npc_state_e;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/npc_cond.sv
module npc_cond (
  input  logic [2:0] mask,
  input  logic [2:0] cc,
  output logic       take
);

  logic [2:0] hit;

  for (genvar i = 0; i < 3; i++) begin : g_hit
    assign hit[i] = mask[i] & cc[i];
  end

  assign take = |hit;

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic [IW-1:0]   ins,
  input  logic [XLEN-1:0] pc_inc,
  input  logic [XLEN-1:0] base_val,
  input  logic [2:0]      cc,
  output npc_sel_e        sel,
  output logic [XLEN-1:0] tgt,
  output logic            link_req,
  output logic [XLEN-1:0] svc_addr
);

  localparam int unsigned OFS_S = 9;
  localparam int unsigned OFS_L = 11;
  localparam int unsigned VECW  = 8;

  logic [3:0]      op;
  logic            take;
  logic [XLEN-1:0] ofs_s_x;
  logic [XLEN-1:0] ofs_l_x;
  logic [XLEN-1:0] rel_s;
  logic [XLEN-1:0] rel_l;

  assign op = ins[15:12];

  npc_cond u_cond (
    .mask (ins[11:9]),
    .cc   (cc),
    .take (take)
  );

  assign ofs_s_x  = {{(XLEN-OFS_S){ins[OFS_S-1]}}, ins[OFS_S-1:0]};
  assign ofs_l_x  = {{(XLEN-OFS_L){ins[OFS_L-1]}}, ins[OFS_L-1:0]};
  assign rel_s    = pc_inc + ofs_s_x;
  assign rel_l    = pc_inc + ofs_l_x;
  assign svc_addr = {{(XLEN-VECW){1'b0}}, ins[VECW-1:0]};

  always_comb begin
    sel      = SEL_INC;
    tgt      = rel_s;
    link_req = 1'b0;
    unique case (op)
      OP_BRC: begin
        tgt = rel_s;
        sel = take ? SEL_TGT : SEL_INC;
      end
      OP_JREG: begin
        tgt = base_val;
        sel = SEL_TGT;
      end
      OP_CALL: begin
        tgt      = ins[11] ? rel_l : base_val;
        sel      = SEL_TGT;
        link_req = 1'b1;
      end
      OP_SVC: begin
        sel = SEL_VEC;
      end
      default: begin
        sel = SEL_INC;
      end
    endcase
  end

endmodule

// File: rtl/npc_seq.sv
module npc_seq
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            ins_vld,
  input  npc_sel_e        sel,
  input  logic [XLEN-1:0] tgt,
  input  logic            link_req,
  input  logic [XLEN-1:0] svc_addr,
  input  logic [XLEN-1:0] pc_inc,
  input  logic [XLEN-1:0] vec_rdata,
  output logic            busy,
  output logic [XLEN-1:0] npc,
  output logic            npc_vld,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            vec_re,
  output logic [XLEN-1:0] vec_addr
);

  npc_state_e      state_q, state_d;
  logic [XLEN-1:0] npc_q, npc_d;
  logic [XLEN-1:0] link_q, link_d;
  logic [XLEN-1:0] hold_q, hold_d;
  logic [XLEN-1:0] vaddr_q, vaddr_d;
  logic            vld_q, vld_d;
  logic            lwe_q, lwe_d;
  logic            vre_q, vre_d;
  logic            accept;
  logic            res_en;
  logic            vec_en;

  assign accept = ins_vld && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    npc_d   = npc_q;
    link_d  = link_q;
    hold_d  = hold_q;
    vaddr_d = vaddr_q;
    vld_d   = 1'b0;
    lwe_d   = 1'b0;
    vre_d   = 1'b0;
    res_en  = 1'b0;
    vec_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (sel == SEL_VEC) begin
            state_d = ST_VEC;
            vre_d   = 1'b1;
            vaddr_d = svc_addr;
            hold_d  = pc_inc;
            vec_en  = 1'b1;
          end else begin
            vld_d  = 1'b1;
            lwe_d  = link_req;
            npc_d  = (sel == SEL_TGT) ? tgt : pc_inc;
            link_d = pc_inc;
            res_en = 1'b1;
          end
        end
      end
      ST_VEC: begin
        state_d = ST_IDLE;
        vld_d   = 1'b1;
        lwe_d   = 1'b1;
        npc_d   = vec_rdata;
        link_d  = hold_q;
        res_en  = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      vld_q   <= 1'b0;
      lwe_q   <= 1'b0;
      vre_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      lwe_q   <= lwe_d;
      vre_q   <= vre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      npc_q  <= '0;
      link_q <= '0;
    end else if (res_en) begin
      npc_q  <= npc_d;
      link_q <= link_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hold_q  <= '0;
      vaddr_q <= '0;
    end else if (vec_en) begin
      hold_q  <= hold_d;
      vaddr_q <= vaddr_d;
    end
  end

  assign busy      = (state_q == ST_VEC);
  assign npc       = npc_q;
  assign npc_vld   = vld_q;
  assign link_we   = lwe_q;
  assign link_data = link_q;
  assign vec_re    = vre_q;
  assign vec_addr  = vaddr_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_vld,
  input  logic [15:0]     ins,
  input  logic [XLEN-1:0] pc_inc,
  input  logic [XLEN-1:0] base_val,
  input  logic [2:0]      cc,
  input  logic [XLEN-1:0] vec_rdata,
  output logic            busy,
  output logic [XLEN-1:0] npc,
  output logic            npc_vld,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            vec_re,
  output logic [XLEN-1:0] vec_addr
);

  logic            rst_sn;
  npc_sel_e        sel;
  logic [XLEN-1:0] tgt;
  logic            link_req;
  logic [XLEN-1:0] svc_addr;

  npc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .ins      (ins),
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .cc       (cc),
    .sel      (sel),
    .tgt      (tgt),
    .link_req (link_req),
    .svc_addr (svc_addr)
  );

  npc_seq #(.XLEN(XLEN)) u_seq (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .ins_vld   (ins_vld),
    .sel       (sel),
    .tgt       (tgt),
    .link_req  (link_req),
    .svc_addr  (svc_addr),
    .pc_inc    (pc_inc),
    .vec_rdata (vec_rdata),
    .busy      (busy),
    .npc       (npc),
    .npc_vld   (npc_vld),
    .link_we   (link_we),
    .link_data (link_data),
    .vec_re    (vec_re),
    .vec_addr  (vec_addr)
  );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XLEN = 16
) (
  input logic            clk,
  input logic            rst_sn,
  input logic            ins_vld,
  input logic [15:0]     ins,
  input logic [XLEN-1:0] pc_inc,
  input logic [XLEN-1:0] base_val,
  input logic            busy,
  input logic [XLEN-1:0] npc,
  input logic            npc_vld,
  input logic            link_we,
  input logic [XLEN-1:0] link_data,
  input logic            vec_re,
  input logic [XLEN-1:0] vec_addr
);

  logic acc;
  assign acc = ins_vld && !busy;

  // R3: empty mask never branches
  a_r3_empty_mask: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc && ins[15:9] == 7'b0) |=> (npc_vld && npc == $past(pc_inc)));

  // R4: register jump lands on the base value
  a_r4_jump_base: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc && ins[15:12] == 4'b1100) |=> (npc_vld && !link_we && npc == $past(base_val)));

  // R5: call links the return address alongside the result
  a_r5_call_link: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc && ins[15:12] == 4'b0100) |=> (npc_vld && link_we && link_data == $past(pc_inc)));

  // R7: vector read is a single cycle followed by the linked result
  a_r7_vec_then_result: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_re |=> (npc_vld && link_we && !vec_re));

  // R7: vector address is zero-extended from eight bits
  a_r7_vec_addr_range: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_re |-> (vec_addr[XLEN-1:8] == '0));

  // R9: an instruction offered while busy produces no result next cycle beyond the pending one
  a_r9_busy_single: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |=> !busy);

  // R10: link write only with a valid result
  a_r10_link_with_vld: assert property (@(posedge clk) disable iff (!rst_sn)
    link_we |-> npc_vld);

  // R10: no result without an accepted instruction or a vector read the cycle before
  a_r10_result_cause: assert property (@(posedge clk) disable iff (!rst_sn)
    (!acc && !vec_re) |=> !npc_vld);

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .ins_vld   (ins_vld),
  .ins       (ins),
  .pc_inc    (pc_inc),
  .base_val  (base_val),
  .busy      (busy),
  .npc       (npc),
  .npc_vld   (npc_vld),
  .link_we   (link_we),
  .link_data (link_data),
  .vec_re    (vec_re),
  .vec_addr  (vec_addr)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        ins_vld;
  logic [15:0] ins;
  logic [15:0] pc_inc;
  logic [15:0] base_val;
  logic [2:0]  cc;
  logic [15:0] vec_rdata;
  logic        busy;
  logic [15:0] npc;
  logic        npc_vld;
  logic        link_we;
  logic [15:0] link_data;
  logic        vec_re;
  logic [15:0] vec_addr;

  int n_chk;
  int n_fail;
  bit done;

  // expected-result scoreboard
  logic [15:0] q_npc[$];
  logic        q_lwe[$];
  logic [15:0] q_link[$];
  logic [15:0] q_vaddr[$];
  string       q_tag[$];

  npc_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_vld   (ins_vld),
    .ins       (ins),
    .pc_inc    (pc_inc),
    .base_val  (base_val),
    .cc        (cc),
    .vec_rdata (vec_rdata),
    .busy      (busy),
    .npc       (npc),
    .npc_vld   (npc_vld),
    .link_we   (link_we),
    .link_data (link_data),
    .vec_re    (vec_re),
    .vec_addr  (vec_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] vec_mem(input logic [15:0] a);
    return (a * 16'h0101) ^ 16'h3C00;
  endfunction

  assign vec_rdata = vec_re ? vec_mem(vec_addr) : 16'hDEAD;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic push_exp(input logic [15:0] i, input logic [15:0] pc,
                          input logic [15:0] bv, input logic [2:0] f, input string tag);
    logic [15:0] e_npc;
    logic        e_lwe;
    logic [15:0] e_va;
    e_npc = pc;
    e_lwe = 1'b0;
    e_va  = 16'hFFFF;
    case (i[15:12])
      4'b0000: if ((i[11] && f[2]) || (i[10] && f[1]) || (i[9] && f[0]))
                 e_npc = pc + {{7{i[8]}}, i[8:0]};
      4'b1100: e_npc = bv;
      4'b0100: begin
        e_lwe = 1'b1;
        e_npc = i[11] ? pc + {{5{i[10]}}, i[10:0]} : bv;
      end
      4'b1111: begin
        e_lwe = 1'b1;
        e_va  = {8'h00, i[7:0]};
        e_npc = vec_mem(e_va);
      end
      default: e_npc = pc;
    endcase
    q_npc.push_back(e_npc);
    q_lwe.push_back(e_lwe);
    q_link.push_back(pc);
    q_vaddr.push_back(e_va);
    q_tag.push_back(tag);
  endtask

  // driver: offers one instruction at a negedge, accepted at the next posedge
  task automatic issue(input logic [15:0] i, input logic [15:0] pc,
                       input logic [15:0] bv, input logic [2:0] f, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    ins      = i;
    pc_inc   = pc;
    base_val = bv;
    cc       = f;
    ins_vld  = 1'b1;
    push_exp(i, pc, bv, f, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    ins_vld = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vec_re) begin
        if (q_vaddr.size() == 0)
          check(1'b0, "R9", "vector read with nothing pending", vec_addr, 16'h0);
        else
          check(vec_addr == q_vaddr[0], "R7", "vec_addr", vec_addr, q_vaddr[0]);
      end
      if (link_we && !npc_vld)
        check(1'b0, "R10", "link_we without npc_vld", {15'b0, link_we}, 16'h0);
      if (npc_vld) begin
        if (q_npc.size() == 0) begin
          check(1'b0, "R9", "unexpected result", npc, 16'h0);
        end else begin
          logic [15:0] en;
          logic        el;
          logic [15:0] ek;
          string       tg;
          en = q_npc.pop_front();
          el = q_lwe.pop_front();
          ek = q_link.pop_front();
          void'(q_vaddr.pop_front());
          tg = q_tag.pop_front();
          check(npc == en, tg, "npc", npc, en);
          check(link_we == el, tg, "link_we", {15'b0, link_we}, {15'b0, el});
          if (el)
            check(link_data == ek, tg, "link_data", link_data, ek);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    done     = 1'b0;
    n_chk    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    ins_vld  = 1'b0;
    ins      = '0;
    pc_inc   = '0;
    base_val = '0;
    cc       = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check({npc_vld, link_we, vec_re, busy} == 4'b0, "R1", "idle outputs",
          {12'b0, npc_vld, link_we, vec_re, busy}, 16'h0);

    // R2: branch on negative, taken, positive offset
    issue(16'b0000_100_000010000, 16'h3001, 16'h0000, 3'b100, "R2");
    // R2: branch on zero with positive flag, not taken
    issue(16'b0000_010_000010000, 16'h3011, 16'h0000, 3'b001, "R2");
    // R2: unconditional mask, negative offset
    issue(16'b0000_111_111111100, 16'h3020, 16'h0000, 3'b010, "R2");
    // R2: wrap around the top of memory
    issue(16'b0000_001_000000001, 16'hFFFF, 16'h0000, 3'b001, "R2");
    // R3: empty mask with all flags set
    issue(16'b0000_000_001000000, 16'h3030, 16'h0000, 3'b111, "R3");
    // R4: register jump
    issue(16'b1100_000_011_000000, 16'h3040, 16'h3500, 3'b000, "R4");
    // R4: return through R7
    issue(16'b1100_000_111_000000, 16'h3041, 16'h4123, 3'b010, "R4");
    // R5: PC-relative call, negative offset
    issue(16'b0100_1_11111110000, 16'h3050, 16'h0000, 3'b000, "R5");
    // R5: PC-relative call, positive offset
    issue(16'b0100_1_00000100000, 16'h3060, 16'hAAAA, 3'b100, "R5");
    // R6: register call through R7: target is old R7, link is pc_inc
    issue(16'b0100_0_00_111_000000, 16'h3070, 16'h5A5A, 3'b000, "R6");
    // R8: arithmetic opcode continues sequentially
    issue(16'b0001_001_010_0_00_011, 16'h3080, 16'h1111, 3'b111, "R8");
    idle();

    // R7: service call, vector read cycle
    issue(16'b1111_0000_00100011, 16'h3090, 16'h0000, 3'b000, "R7");
    @(negedge clk);
    check(busy && vec_re, "R7", "busy/vec_re after call", {14'b0, busy, vec_re}, 16'h3);
    // R9: offer a jump while busy; it must be dropped
    ins      = 16'b1100_000_010_000000;
    base_val = 16'hBEEF;
    ins_vld  = 1'b1;
    @(negedge clk);
    ins_vld = 1'b0;
    repeat (3) @(negedge clk);
    check(q_npc.size() == 0, "R9", "pending results", q_npc.size(), 16'h0);

    // R7: service call at the top vector index, back to back with a branch (R10)
    issue(16'b1111_0000_11111111, 16'h30A0, 16'h0000, 3'b000, "R7");
    issue(16'b0000_001_000000011, 16'h30A1, 16'h0000, 3'b001, "R10");
    issue(16'b1100_000_001_000000, 16'h30A2, 16'h0777, 3'b000, "R10");
    idle();
    repeat (4) @(negedge clk);
    check(!npc_vld && !link_we, "R10", "quiet after drain", {14'b0, npc_vld, link_we}, 16'h0);
    check(q_npc.size() == 0, "R10", "all results seen", q_npc.size(), 16'h0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule